// File: doc/BRIEF.md
# Indexed Set/Clear Channel Control Bank

This block holds the per-channel control and status bits of a 64-channel DMA controller, together with its global control word and a captured error report. Each per-channel quantity (request enable, error interrupt enable, interrupt pending, error pending, done, start) is a 64-bit vector, visible to software as an upper and a lower 32-bit word. Software can rewrite the enable words whole and can clear pending bits with write-one-to-clear. Its main path, though, is a set of command registers: each takes a channel number and sets or clears that one channel's bit. This removes the need for read-modify-write sequences that could race with hardware events.

The channel engines report into the bank. A completion pulse marks a channel done and raises its interrupt. An error report marks the channel's error bit and, when no report is held, is latched into the error status word. A start acknowledge clears a start request. The bank drives each channel's request enable, start request and interrupt line. It also passes the live hardware request lines back to software and drives the two round-robin arbitration enables.

Top module: `dma_chctl_regs`

## Requirements
- R1: After reset, every per-channel vector, the control word and the error status word read zero, and all of `req_en_o`, `start_o`, `irq_o`, `rr_chan_en_o` and `rr_group_en_o` are low.
- R2: Channel c maps to bit c of the lower word when c < 32, and to bit c-32 of the upper word otherwise. The hardware request status words (upper 0x30, lower 0x34) show `hw_req_i` as it is in the current cycle.
- R3: A write of channel number N to a command register acts on channel N. The channel number is taken from `bus_wdata[5:0]`. The effect is visible one cycle after the write. Command addresses: 0x40 set request enable, 0x44 clear request enable, 0x48 set error interrupt enable, 0x4C clear error interrupt enable. Request enable reads at 0x08/0x0C and error interrupt enable at 0x10/0x14 (upper/lower).
- R4: A command write whose `bus_wdata[7:6]` is not zero (channel above 63) changes nothing. A read of any command address (0x40 to 0x5C) returns zero.
- R5: A pulse on `done_evt_i[c]` sets both done[c] and interrupt pending[c]. Command 0x50 clears one channel's interrupt pending bit, and 0x5C clears one done bit. Interrupt pending reads at 0x18/0x1C and done at 0x28/0x2C.
- R6: The interrupt pending words (0x18/0x1C) and error pending words (0x20/0x24) are write-one-to-clear. Writing all ones clears every channel in that word. Zero bits leave their channels unchanged.
- R7: `irq_o[c]` is high when interrupt pending[c] is set, or when error pending[c] and error interrupt enable[c] are both set.
- R8: An error report sets error pending for its channel. When the error status word (0x04) is not valid, the report is captured: bit 31 = 1, bits 13:8 = channel, bits 15:14 = `err_rpt_cause_i[9:8]`, bits 7:0 = `err_rpt_cause_i[7:0]`. While the word is valid, later reports leave it unchanged. Clear-error command 0x54 clears that channel's error pending bit and empties the status word.
- R9: A hardware event that sets a bit wins over a software clear of the same bit in the same cycle.
- R10: Command 0x58 sets start[c], which drives `start_o[c]` and reads at 0x38/0x3C. A pulse on `start_ack_i[c]` clears it.
- R11: Control word 0x00: bit 2 enables round-robin channel arbitration (`rr_chan_en_o`) and bit 3 enables round-robin group arbitration (`rr_group_en_o`). Other bits read zero.
- R12: A write to a request enable or error interrupt enable word replaces all 32 channels of that word and leaves the other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| done_evt_i | input | 64 | Per-channel completion pulse |
| start_ack_i | input | 64 | Per-channel start acknowledge |
| hw_req_i | input | 64 | Live per-channel hardware request lines |
| err_rpt_valid_i | input | 1 | Error report strobe |
| err_rpt_chan_i | input | 6 | Channel of the error report |
| err_rpt_cause_i | input | 10 | Error cause flags |
| req_en_o | output | 64 | Per-channel request enable |
| start_o | output | 64 | Per-channel start request |
| irq_o | output | 64 | Per-channel interrupt |
| rr_chan_en_o | output | 1 | Round-robin channel arbitration enable |
| rr_group_en_o | output | 1 | Round-robin group arbitration enable |

## Verification
The hardest case to reach is a collision: a hardware event and a software command land on the same bit in the same clock. Examples are a completion pulse during a clear-interrupt command, or a new error report in the cycle the status word is cleared. The bench drives the event input and the bus write on the same falling edge, so both reach the same rising edge. It then reads the word back. A second error report, sent while the first is still held, shows that the status word holds its first capture while the second channel's error pending bit still sets.

// File: rtl/dma_chctl_pkg.sv
`timescale 1ns/1ps
package dma_chctl_pkg;
  localparam int NCH    = 64;
  localparam int WORD_W = 32;
  localparam int CH_W   = $clog2(NCH);
  localparam int ADDR_W = 8;
  localparam int CAUSE_W = 10;
  localparam int NCMD   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] A_ERRSTAT = 8'h04;
  localparam logic [ADDR_W-1:0] A_REQEN_H = 8'h08;
  localparam logic [ADDR_W-1:0] A_REQEN_L = 8'h0C;
  localparam logic [ADDR_W-1:0] A_EIE_H   = 8'h10;
  localparam logic [ADDR_W-1:0] A_EIE_L   = 8'h14;
  localparam logic [ADDR_W-1:0] A_INT_H   = 8'h18;
  localparam logic [ADDR_W-1:0] A_INT_L   = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ERR_H   = 8'h20;
  localparam logic [ADDR_W-1:0] A_ERR_L   = 8'h24;
  localparam logic [ADDR_W-1:0] A_DONE_H  = 8'h28;
  localparam logic [ADDR_W-1:0] A_DONE_L  = 8'h2C;
  localparam logic [ADDR_W-1:0] A_HWRQ_H  = 8'h30;
  localparam logic [ADDR_W-1:0] A_HWRQ_L  = 8'h34;
  localparam logic [ADDR_W-1:0] A_START_H = 8'h38;
  localparam logic [ADDR_W-1:0] A_START_L = 8'h3C;
  localparam logic [ADDR_W-1:0] A_CMD_BASE = 8'h40;

  // command slots, each one word apart from A_CMD_BASE
  typedef enum int {
    CMD_SET_REQ   = 0,
    CMD_CLR_REQ   = 1,
    CMD_SET_EIE   = 2,
    CMD_CLR_EIE   = 3,
    CMD_CLR_INT   = 4,
    CMD_CLR_ERR   = 5,
    CMD_SET_START = 6,
    CMD_CLR_DONE  = 7
  } cmd_slot_e;

  localparam int CTRL_RR_CHAN  = 2;
  localparam int CTRL_RR_GROUP = 3;

  function automatic logic [ADDR_W-1:0] cmd_addr(int slot);
    return A_CMD_BASE + ADDR_W'(4 * slot);
  endfunction

  function automatic logic is_cmd_addr(logic [ADDR_W-1:0] a);
    return (a >= A_CMD_BASE) && (a < cmd_addr(NCMD)) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [NCH-1:0] chan_onehot(logic [CH_W-1:0] ch);
    logic [NCH-1:0] v;
    v = '0;
    v[ch] = 1'b1;
    return v;
  endfunction

  // place a 32-bit word into the upper or lower half of a channel vector
  function automatic logic [NCH-1:0] word_place(logic upper, logic [WORD_W-1:0] d);
    return upper ? {d, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, d};
  endfunction

  function automatic logic [WORD_W-1:0] word_pick(logic upper, logic [NCH-1:0] v);
    return upper ? v[NCH-1:WORD_W] : v[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] errstat_pack(logic [CH_W-1:0] ch,
                                                     logic [CAUSE_W-1:0] cause);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[15:14] = cause[9:8];
    w[13:8]  = ch;
    w[7:0]   = cause[7:0];
    return w;
  endfunction
endpackage

// File: rtl/chctl_cmd_decode.sv
`timescale 1ns/1ps
module chctl_cmd_decode
  import dma_chctl_pkg::*;
(
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        cmd_byte,
  output logic [NCMD-1:0]   cmd_fire_o,
  output logic [NCH-1:0]    cmd_vec_o
);
  logic ch_in_range;
  assign ch_in_range = (cmd_byte[7:CH_W] == '0);
  assign cmd_vec_o   = chan_onehot(cmd_byte[CH_W-1:0]);

  for (genvar i = 0; i < NCMD; i++) begin : g_cmd
    assign cmd_fire_o[i] = bus_wr && ch_in_range && (bus_addr == cmd_addr(i));
  end
endmodule

// File: rtl/chctl_bitvec.sv
`timescale 1ns/1ps
module chctl_bitvec #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // set has priority over clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/chctl_errstat.sv
`timescale 1ns/1ps
module chctl_errstat
  import dma_chctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rpt_valid_i,
  input  logic [CH_W-1:0]    rpt_chan_i,
  input  logic [CAUSE_W-1:0] rpt_cause_i,
  input  logic               clr_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               capture_o
);
  assign capture_o = rpt_valid_i && (!word_o[31] || clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_o <= '0;
    else if (capture_o) word_o <= errstat_pack(rpt_chan_i, rpt_cause_i);
    else if (clr_i)     word_o <= '0;
  end
endmodule

// File: rtl/dma_chctl_regs.sv
`timescale 1ns/1ps
module dma_chctl_regs
  import dma_chctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [63:0]        done_evt_i,
  input  logic [63:0]        start_ack_i,
  input  logic [63:0]        hw_req_i,
  input  logic               err_rpt_valid_i,
  input  logic [5:0]         err_rpt_chan_i,
  input  logic [9:0]         err_rpt_cause_i,
  output logic [63:0]        req_en_o,
  output logic [63:0]        start_o,
  output logic [63:0]        irq_o,
  output logic               rr_chan_en_o,
  output logic               rr_group_en_o
);
  logic [NCMD-1:0] cmd_fire;
  logic [NCH-1:0]  cmd_vec;
  logic            upper_sel;
  logic [NCH-1:0]  wr_word;

  // named event wires for the checker
  logic            clr_err_fire;
  logic            err_capture;
  logic [WORD_W-1:0] errstat_w;

  logic [NCH-1:0] req_q, eie_q, int_q, err_q, done_q, start_q;
  logic [NCH-1:0] req_set, req_clr, eie_set, eie_clr;
  logic [NCH-1:0] int_set, int_clr, err_set, err_clr;
  logic [NCH-1:0] done_set, done_clr, start_set, start_clr;
  logic [1:0]     ctrl_q;

  chctl_cmd_decode u_dec (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .cmd_byte   (bus_wdata[7:0]),
    .cmd_fire_o (cmd_fire),
    .cmd_vec_o  (cmd_vec)
  );

  assign upper_sel = ~bus_addr[2];
  assign wr_word   = word_place(upper_sel, bus_wdata);

  function automatic logic word_hit(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] hi_a);
    return (a == hi_a) || (a == hi_a + ADDR_W'(4));
  endfunction

  logic wr_req_word, wr_eie_word, wr_int_word, wr_err_word;
  assign wr_req_word = bus_wr && word_hit(bus_addr, A_REQEN_H);
  assign wr_eie_word = bus_wr && word_hit(bus_addr, A_EIE_H);
  assign wr_int_word = bus_wr && word_hit(bus_addr, A_INT_H);
  assign wr_err_word = bus_wr && word_hit(bus_addr, A_ERR_H);

  function automatic logic [NCH-1:0] gate(logic en, logic [NCH-1:0] v);
    return en ? v : '0;
  endfunction

  // whole-word writes: clear the addressed word, set the written ones
  assign req_set  = gate(cmd_fire[CMD_SET_REQ], cmd_vec) | gate(wr_req_word, wr_word);
  assign req_clr  = gate(cmd_fire[CMD_CLR_REQ], cmd_vec) |
                    gate(wr_req_word, word_place(upper_sel, '1));
  assign eie_set  = gate(cmd_fire[CMD_SET_EIE], cmd_vec) | gate(wr_eie_word, wr_word);
  assign eie_clr  = gate(cmd_fire[CMD_CLR_EIE], cmd_vec) |
                    gate(wr_eie_word, word_place(upper_sel, '1));
  assign int_set  = done_evt_i;
  assign int_clr  = gate(cmd_fire[CMD_CLR_INT], cmd_vec) | gate(wr_int_word, wr_word);
  assign err_set  = gate(err_rpt_valid_i, chan_onehot(err_rpt_chan_i));
  assign err_clr  = gate(cmd_fire[CMD_CLR_ERR], cmd_vec) | gate(wr_err_word, wr_word);
  assign done_set = done_evt_i;
  assign done_clr = gate(cmd_fire[CMD_CLR_DONE], cmd_vec);
  assign start_set = gate(cmd_fire[CMD_SET_START], cmd_vec);
  assign start_clr = start_ack_i;

  chctl_bitvec #(.N(NCH)) u_req   (.clk(clk), .rst_n(rst_n), .set_i(req_set),   .clr_i(req_clr),   .q_o(req_q));
  chctl_bitvec #(.N(NCH)) u_eie   (.clk(clk), .rst_n(rst_n), .set_i(eie_set),   .clr_i(eie_clr),   .q_o(eie_q));
  chctl_bitvec #(.N(NCH)) u_int   (.clk(clk), .rst_n(rst_n), .set_i(int_set),   .clr_i(int_clr),   .q_o(int_q));
  chctl_bitvec #(.N(NCH)) u_err   (.clk(clk), .rst_n(rst_n), .set_i(err_set),   .clr_i(err_clr),   .q_o(err_q));
  chctl_bitvec #(.N(NCH)) u_done  (.clk(clk), .rst_n(rst_n), .set_i(done_set),  .clr_i(done_clr),  .q_o(done_q));
  chctl_bitvec #(.N(NCH)) u_start (.clk(clk), .rst_n(rst_n), .set_i(start_set), .clr_i(start_clr), .q_o(start_q));

  assign clr_err_fire = cmd_fire[CMD_CLR_ERR];

  chctl_errstat u_estat (
    .clk         (clk),
    .rst_n       (rst_n),
    .rpt_valid_i (err_rpt_valid_i),
    .rpt_chan_i  (err_rpt_chan_i),
    .rpt_cause_i (err_rpt_cause_i),
    .clr_i       (clr_err_fire),
    .word_o      (errstat_w),
    .capture_o   (err_capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (bus_wr && bus_addr == A_CTRL) ctrl_q <= {bus_wdata[CTRL_RR_GROUP], bus_wdata[CTRL_RR_CHAN]};
  end

  assign rr_chan_en_o  = ctrl_q[0];
  assign rr_group_en_o = ctrl_q[1];
  assign req_en_o      = req_q;
  assign start_o       = start_q;
  assign irq_o         = int_q | (err_q & eie_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:    begin
                   bus_rdata[CTRL_RR_CHAN]  = ctrl_q[0];
                   bus_rdata[CTRL_RR_GROUP] = ctrl_q[1];
                 end
      A_ERRSTAT: bus_rdata = errstat_w;
      A_REQEN_H, A_REQEN_L: bus_rdata = word_pick(upper_sel, req_q);
      A_EIE_H,   A_EIE_L:   bus_rdata = word_pick(upper_sel, eie_q);
      A_INT_H,   A_INT_L:   bus_rdata = word_pick(upper_sel, int_q);
      A_ERR_H,   A_ERR_L:   bus_rdata = word_pick(upper_sel, err_q);
      A_DONE_H,  A_DONE_L:  bus_rdata = word_pick(upper_sel, done_q);
      A_HWRQ_H,  A_HWRQ_L:  bus_rdata = word_pick(upper_sel, hw_req_i);
      A_START_H, A_START_L: bus_rdata = word_pick(upper_sel, start_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chctl_chk.sv
`timescale 1ns/1ps
module dma_chctl_chk
  import dma_chctl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [63:0] done_evt_i,
  input logic [63:0] irq_o,
  input logic [63:0] req_en_o,
  input logic [31:0] errstat_w,
  input logic        clr_err_fire
);
  // R5: a completion pulse raises the channel interrupt on the next cycle
  a_r5_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_evt_i) |=> ((irq_o & $past(done_evt_i)) == $past(done_evt_i)));

  // R4: out-of-range channel numbers leave the request enables untouched
  a_r4_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == cmd_addr(CMD_SET_REQ) || bus_addr == cmd_addr(CMD_CLR_REQ))
     && bus_wdata[7:6] != 2'b00) |=> $stable(req_en_o));

  // R4: command registers read as zero
  a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_addr(bus_addr) |-> (bus_rdata == 32'h0));

  // R8: a valid status word is held until the clear-error command
  a_r8_errstat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (errstat_w[31] && !clr_err_fire) |=> $stable(errstat_w));

  // R3: set-request command enables the addressed channel
  a_r3_set_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == cmd_addr(CMD_SET_REQ) && bus_wdata[7:6] == 2'b00)
    |=> req_en_o[$past(bus_wdata[5:0])]);
endmodule

bind dma_chctl_regs dma_chctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .done_evt_i   (done_evt_i),
  .irq_o        (irq_o),
  .req_en_o     (req_en_o),
  .errstat_w    (errstat_w),
  .clr_err_fire (clr_err_fire)
);

// File: tb/dma_chctl_regs_tb.sv
`timescale 1ns/1ps
module dma_chctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] done_evt_i = '0, start_ack_i = '0, hw_req_i = '0;
  logic        err_rpt_valid_i = 1'b0;
  logic [5:0]  err_rpt_chan_i = '0;
  logic [9:0]  err_rpt_cause_i = '0;
  logic [63:0] req_en_o, start_o, irq_o;
  logic        rr_chan_en_o, rr_group_en_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  dma_chctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_evt_i(done_evt_i),
    .start_ack_i(start_ack_i), .hw_req_i(hw_req_i),
    .err_rpt_valid_i(err_rpt_valid_i), .err_rpt_chan_i(err_rpt_chan_i),
    .err_rpt_cause_i(err_rpt_cause_i), .req_en_o(req_en_o), .start_o(start_o),
    .irq_o(irq_o), .rr_chan_en_o(rr_chan_en_o), .rr_group_en_o(rr_group_en_o)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd1,  8'h00, 32'h0, 32'h0},          // R1 control word
    '{1'b0, 4'd1,  8'h04, 32'h0, 32'h0},          // R1 error status
    '{1'b0, 4'd1,  8'h0C, 32'h0, 32'h0},          // R1 request enable low
    '{1'b0, 4'd1,  8'h18, 32'h0, 32'h0},          // R1 int pending high
    '{1'b1, 4'd3,  8'h40, 32'd5, 32'h0},          // R3 set req ch5
    '{1'b0, 4'd3,  8'h0C, 32'h0, 32'h0000_0020},
    '{1'b1, 4'd2,  8'h40, 32'd40, 32'h0},         // R2 ch40 lands in upper bit 8
    '{1'b0, 4'd2,  8'h08, 32'h0, 32'h0000_0100},
    '{1'b1, 4'd4,  8'h40, 32'h45, 32'h0},         // R4 channel 69 ignored
    '{1'b0, 4'd4,  8'h0C, 32'h0, 32'h0000_0020},
    '{1'b0, 4'd4,  8'h08, 32'h0, 32'h0000_0100},
    '{1'b0, 4'd4,  8'h40, 32'h0, 32'h0},          // R4 command reads zero
    '{1'b1, 4'd3,  8'h44, 32'd5, 32'h0},          // R3 clear req ch5
    '{1'b0, 4'd3,  8'h0C, 32'h0, 32'h0},
    '{1'b1, 4'd3,  8'h48, 32'd63, 32'h0},         // R3 set eie ch63
    '{1'b0, 4'd3,  8'h10, 32'h0, 32'h8000_0000},
    '{1'b1, 4'd11, 8'h00, 32'hFFFF_FFFF, 32'h0},  // R11 only bits 2,3 stick
    '{1'b0, 4'd11, 8'h00, 32'h0, 32'h0000_000C},
    '{1'b1, 4'd12, 8'h0C, 32'hA5A5_A5A5, 32'h0},  // R12 whole-word write
    '{1'b0, 4'd12, 8'h0C, 32'h0, 32'hA5A5_A5A5},
    '{1'b0, 4'd12, 8'h08, 32'h0, 32'h0000_0100},
    '{1'b1, 4'd3,  8'h4C, 32'd63, 32'h0}          // R3 clear eie ch63
  };

  task automatic chk(int req, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, $sformatf("read %h", a), {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  task automatic err_rpt(logic [5:0] ch, logic [9:0] cause);
    @(negedge clk);
    err_rpt_valid_i = 1'b1; err_rpt_chan_i = ch; err_rpt_cause_i = cause;
    @(negedge clk);
    err_rpt_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done_run) begin
      n_bad++;
      $display("FAIL watchdog expired, all R");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 outputs after reset
    chk(1, "req_en_o", req_en_o, '0);
    chk(1, "irq_o", irq_o, '0);
    chk(1, "start_o", start_o, '0);
    chk(1, "rr enables", {62'h0, rr_group_en_o, rr_chan_en_o}, '0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else           rd(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
    end
    rd(3, 8'h10, 32'h0);   // R3 eie ch63 cleared
    chk(11, "rr outputs", {62'h0, rr_group_en_o, rr_chan_en_o}, 64'h3);

    // R2 live hardware request lines
    @(negedge clk);
    hw_req_i = 64'h0000_0004_8000_0001;
    rd(2, 8'h30, 32'h0000_0004);
    rd(2, 8'h34, 32'h8000_0001);
    hw_req_i = '0;

    // R5 completion events on ch3 and ch33
    @(negedge clk);
    done_evt_i = (64'd1 << 3) | (64'd1 << 33);
    @(negedge clk);
    done_evt_i = '0;
    rd(5, 8'h1C, 32'h0000_0008);
    rd(5, 8'h18, 32'h0000_0002);
    rd(5, 8'h2C, 32'h0000_0008);
    chk(7, "irq_o after done", irq_o, (64'd1 << 3) | (64'd1 << 33));
    // R6 zero write is no-op, all ones clears the word
    wr(8'h1C, 32'h0);
    rd(6, 8'h1C, 32'h0000_0008);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(6, 8'h1C, 32'h0);
    rd(6, 8'h18, 32'h0000_0002);
    // R5 clear-int command on ch33, clear-done on ch3
    wr(8'h50, 32'd33);
    rd(5, 8'h18, 32'h0);
    wr(8'h5C, 32'd3);
    rd(5, 8'h2C, 32'h0);

    // R8 first error captured
    err_rpt(6'd10, 10'b10_0000_0001);
    rd(8, 8'h04, 32'h8000_8A01);
    rd(8, 8'h24, 32'h0000_0400);
    chk(7, "irq_o err without enable", irq_o, '0);
    wr(8'h48, 32'd10);     // R7 enable error interrupt ch10
    chk(7, "irq_o err with enable", irq_o, 64'd1 << 10);
    err_rpt(6'd12, 10'b01_0000_0100);
    rd(8, 8'h04, 32'h8000_8A01);   // R8 held
    rd(8, 8'h24, 32'h0000_1400);
    wr(8'h54, 32'd10);
    rd(8, 8'h04, 32'h0);
    rd(8, 8'h24, 32'h0000_1000);
    wr(8'h24, 32'hFFFF_FFFF);      // R6 error word cleared
    rd(6, 8'h24, 32'h0);

    // R9 completion beats clear-int in the same cycle
    @(negedge clk);
    done_evt_i = 64'd1 << 7;
    bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = 32'd7;
    @(negedge clk);
    done_evt_i = '0; bus_wr = 1'b0;
    rd(9, 8'h1C, 32'h0000_0080);

    // R10 start request and acknowledge
    wr(8'h58, 32'd20);
    chk(10, "start_o set", start_o, 64'd1 << 20);
    rd(10, 8'h3C, 32'h0010_0000);
    @(negedge clk);
    start_ack_i = 64'd1 << 20;
    @(negedge clk);
    start_ack_i = '0;
    chk(10, "start_o acked", start_o, '0);

    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule